// File: doc/BRIEF.md
# Output Driver Impedance Calibration Controller

This block is the memory-device side of output driver impedance calibration. An extended mode register write carries a three-bit operation field. The field selects one of five calibration modes:

- exit,
- forced drive high,
- forced drive low,
- step adjustment,
- load of the default strength.

In the two forced-drive modes the block tells the I/O ring which level to put on the data pins and on the true and complementary strobes. The controller can then measure the driver from the outside.

In adjustment mode the controller sends a four-beat code serially on the data pins, with the same value on every lane. The device side sees it on a single-bit input. The block assembles the code and turns it into separate step commands for the pull-up and pull-down legs. It then moves two saturating step counters, and their values select the driver strength. Operation codes with no assigned meaning are ignored and raise a one-cycle flag.

Top module: `drv_imp_cal`

## Requirements
- R1: After a synchronous reset the mode is exit, both step outputs equal DEF_STEP (default 4), `drv_force`, `drv_lvl_dq`, `drv_lvl_dqsn` and `rsvd_op` are 0.
- R2: A write with op 001 makes, from the next cycle, `drv_force`=1, `drv_lvl_dq`=1 (data and true strobe high), `drv_lvl_dqsn`=0; op 010 gives `drv_force`=1, `drv_lvl_dq`=0, `drv_lvl_dqsn`=1.
- R3: A write with op 000 releases forced drive (`drv_force`, `drv_lvl_dq` and `drv_lvl_dqsn` all 0 from the next cycle) and leaves both step values unchanged.
- R4: A write with op 111 loads DEF_STEP into both step counters at the same clock edge, takes priority over any pending step update, and does not force the pins.
- R5: After a write with op 100 the block is in adjust mode. A beat is accepted on a cycle with `beat_vld`=1 and `mrs_wr`=0 while in adjust mode. Four accepted beats form one code, the first beat being DT0. The step counters change at the edge one cycle after the edge that accepts the fourth beat. Every write of op 100 restarts the beat count, and successive bursts follow with no gap needed.
- R6: The code is written DT0 DT1 DT2 DT3. DT3=1 raises pull-up one step and DT2=1 lowers it. DT1=1 raises pull-down and DT0=1 lowers it. So 0000 does nothing, 0001/0010 move only pull-up up/down, 0100/1000 move only pull-down up/down, 0101 raises both, 0110 lowers pull-up and raises pull-down, 1001 raises pull-up and lowers pull-down, and 1010 lowers both.
- R7: A code with both DT2 and DT3 set, or with both DT0 and DT1 set, is reserved and changes neither counter.
- R8: Each counter spans 0..7. A raise at 7 or a lower at 0 leaves that counter unchanged, and no step moves a counter by more than one.
- R9: A write with op 011, 101 or 110 keeps the current mode and pin levels, and `rsvd_op` is 1 in exactly the cycle after that write.
- R10: Beats presented outside adjust mode change no counter and do not count toward a later burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_wr | input | 1 | Extended mode register write strobe |
| mrs_op | input | 3 | Calibration operation field of that write |
| beat_vld | input | 1 | Burst beat present on this cycle |
| beat_dt | input | 1 | Burst beat value, common to all data lanes |
| pu_step | output | STEP_W | Current pull-up step code |
| pd_step | output | STEP_W | Current pull-down step code |
| drv_force | output | 1 | Pins are forced by calibration |
| drv_lvl_dq | output | 1 | Forced level for data pins and true strobe |
| drv_lvl_dqsn | output | 1 | Forced level for complementary strobe |
| rsvd_op | output | 1 | Unassigned operation code was written |

## Verification
The assertions take for granted that a default-load write is the only event that can move a counter by more than one step. They also take for granted that a counter can move only when a write occurs or when a decoded burst update is pending. The stimulus never asserts `beat_vld` in the same cycle as `mrs_wr`, except in one directed case that checks such a beat is dropped. Random traffic draws operation codes from all eight values, including the unassigned ones. It interleaves beats in every mode, so that bursts straddle mode changes and some beats land outside adjustment.

// File: rtl/drv_cal_pkg.sv
package drv_cal_pkg;

    localparam int BURST_LEN = 4;

    typedef enum logic [2:0] {
        CM_EXIT = 3'b000,
        CM_HIGH = 3'b001,
        CM_LOW  = 3'b010,
        CM_ADJ  = 3'b100,
        CM_DEF  = 3'b111
    } cal_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2
    } step_cmd_e;

    typedef struct packed {
        step_cmd_e pu;
        step_cmd_e pd;
    } step_req_t;

    typedef struct packed {
        logic force_en;
        logic lvl_dq;
        logic lvl_dqsn;
    } drive_t;

    function automatic logic op_known(input logic [2:0] op);
        return (op == CM_EXIT) || (op == CM_HIGH) || (op == CM_LOW) ||
               (op == CM_ADJ)  || (op == CM_DEF);
    endfunction

    function automatic step_cmd_e leg_cmd(input logic up, input logic dn);
        if (up && !dn) return ST_UP;
        if (dn && !up) return ST_DN;
        return ST_HOLD;
    endfunction

    // code[3] is the first beat (DT0), code[0] the last (DT3)
    function automatic step_req_t burst_to_req(input logic [BURST_LEN-1:0] code);
        step_req_t r;
        logic      bad;
        bad  = (code[0] & code[1]) | (code[2] & code[3]);
        r.pu = bad ? ST_HOLD : leg_cmd(code[0], code[1]);
        r.pd = bad ? ST_HOLD : leg_cmd(code[2], code[3]);
        return r;
    endfunction

    function automatic drive_t mode_drive(input cal_mode_e m);
        drive_t d;
        d.force_en = (m == CM_HIGH) || (m == CM_LOW);
        d.lvl_dq   = (m == CM_HIGH);
        d.lvl_dqsn = (m == CM_LOW);
        return d;
    endfunction

endpackage

// File: rtl/cal_mode_ctl.sv
module cal_mode_ctl
    import drv_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mrs_wr,
    input  logic [2:0] mrs_op,
    output cal_mode_e mode_o,
    output logic      rsvd_o,
    output logic      adj_start_o,
    output logic      def_load_o
);
    cal_mode_e mode_q;
    logic      rsvd_q;
    logic      known;

    assign known = op_known(mrs_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CM_EXIT;
            rsvd_q <= 1'b0;
        end else begin
            if (mrs_wr && known) begin
                mode_q <= cal_mode_e'(mrs_op);
            end
            rsvd_q <= mrs_wr && !known;
        end
    end

    assign mode_o      = mode_q;
    assign rsvd_o      = rsvd_q;
    assign adj_start_o = mrs_wr && (mrs_op == CM_ADJ);
    assign def_load_o  = mrs_wr && (mrs_op == CM_DEF);
endmodule

// File: rtl/burst_capture.sv
module burst_capture
    import drv_cal_pkg::*;
#(
    parameter int LEN = BURST_LEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adj_mode,
    input  logic           adj_start,
    input  logic           block,
    input  logic           beat_vld,
    input  logic           beat_dt,
    output logic [LEN-1:0] code_o,
    output logic           upd_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0]  beat_q;
    logic [LEN-1:0] shift_q;
    logic [LEN-1:0] shift_nx;
    logic [LEN-1:0] code_q;
    logic           upd_q;
    logic           accept;

    assign accept   = adj_mode && beat_vld && !block;
    assign shift_nx = {shift_q[LEN-2:0], beat_dt};

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            shift_q <= '0;
            code_q  <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (adj_start) begin
                beat_q <= '0;
            end else if (accept) begin
                shift_q <= shift_nx;
                beat_q  <= (beat_q == LAST) ? '0 : beat_q + CW'(1);
                if (beat_q == LAST) begin
                    code_q <= shift_nx;
                    upd_q  <= 1'b1;
                end
            end
        end
    end

    assign code_o = code_q;
    assign upd_o  = upd_q;
endmodule

// File: rtl/step_cnt.sv
module step_cnt
    import drv_cal_pkg::*;
#(
    parameter int W   = 3,
    parameter int DEF = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         cmd_vld,
    input  step_cmd_e    cmd,
    output logic [W-1:0] step_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] DEFV = W'(DEF);

    logic [W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            step_q <= DEFV;
        end else if (cmd_vld) begin
            case (cmd)
                ST_UP:   if (step_q != MAXV) step_q <= step_q + W'(1);
                ST_DN:   if (step_q != '0)   step_q <= step_q - W'(1);
                default: step_q <= step_q;
            endcase
        end
    end

    assign step_o = step_q;
endmodule

// File: rtl/drv_imp_cal.sv
module drv_imp_cal
    import drv_cal_pkg::*;
#(
    parameter int STEP_W   = 3,
    parameter int DEF_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrs_wr,
    input  logic [2:0]        mrs_op,
    input  logic              beat_vld,
    input  logic              beat_dt,
    output logic [STEP_W-1:0] pu_step,
    output logic [STEP_W-1:0] pd_step,
    output logic              drv_force,
    output logic              drv_lvl_dq,
    output logic              drv_lvl_dqsn,
    output logic              rsvd_op
);
    localparam int NLEG = 2;

    cal_mode_e            mode;
    logic                 adj_start;
    logic                 def_load;
    logic [BURST_LEN-1:0] code;
    logic                 upd_vld;
    step_req_t            req;
    drive_t               drv;
    step_cmd_e            leg_cmd_a [NLEG];
    logic [STEP_W-1:0]    leg_step  [NLEG];

    cal_mode_ctl u_mode (
        .clk         (clk),
        .rst         (rst),
        .mrs_wr      (mrs_wr),
        .mrs_op      (mrs_op),
        .mode_o      (mode),
        .rsvd_o      (rsvd_op),
        .adj_start_o (adj_start),
        .def_load_o  (def_load)
    );

    burst_capture #(.LEN(BURST_LEN)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .adj_mode  (mode == CM_ADJ),
        .adj_start (adj_start),
        .block     (mrs_wr),
        .beat_vld  (beat_vld),
        .beat_dt   (beat_dt),
        .code_o    (code),
        .upd_o     (upd_vld)
    );

    assign req          = burst_to_req(code);
    assign leg_cmd_a[0] = req.pu;
    assign leg_cmd_a[1] = req.pd;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        step_cnt #(.W(STEP_W), .DEF(DEF_STEP)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .load    (def_load),
            .cmd_vld (upd_vld),
            .cmd     (leg_cmd_a[g]),
            .step_o  (leg_step[g])
        );
    end

    assign pu_step = leg_step[0];
    assign pd_step = leg_step[1];

    assign drv          = mode_drive(mode);
    assign drv_force    = drv.force_en;
    assign drv_lvl_dq   = drv.lvl_dq;
    assign drv_lvl_dqsn = drv.lvl_dqsn;
endmodule

// File: rtl/drv_imp_cal_chk.sv
module drv_imp_cal_chk #(
    parameter int STEP_W   = 3,
    parameter int DEF_STEP = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mrs_wr,
    input logic [2:0]        mrs_op,
    input logic [STEP_W-1:0] pu_step,
    input logic [STEP_W-1:0] pd_step,
    input logic              drv_force,
    input logic              drv_lvl_dq,
    input logic              drv_lvl_dqsn,
    input logic              rsvd_op,
    input logic              upd_vld
);
    localparam logic [STEP_W-1:0] MAXV = {STEP_W{1'b1}};
    localparam logic [STEP_W-1:0] DEFV = STEP_W'(DEF_STEP);

    logic op_unused;
    assign op_unused = (mrs_op == 3'b011) || (mrs_op == 3'b101) || (mrs_op == 3'b110);

    a_r2_lvl_excl: assert property (@(posedge clk) disable iff (rst)
        drv_force |-> (drv_lvl_dq != drv_lvl_dqsn));

    a_r3_release_low: assert property (@(posedge clk) disable iff (rst)
        !drv_force |-> (!drv_lvl_dq && !drv_lvl_dqsn));

    a_r4_default_load: assert property (@(posedge clk) disable iff (rst)
        (mrs_wr && mrs_op == 3'b111) |=> (pu_step == DEFV && pd_step == DEFV));

    a_r7_hold_no_upd: assert property (@(posedge clk) disable iff (rst)
        (!mrs_wr && !upd_vld) |=> ($stable(pu_step) && $stable(pd_step)));

    a_r8_pu_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (pu_step == MAXV && !mrs_wr) |=> (pu_step != '0));

    a_r8_pd_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (pd_step == '0 && !mrs_wr) |=> (pd_step != MAXV));

    a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
        !mrs_wr |=> ((int'(pu_step) - int'($past(pu_step)) <= 1) &&
                     (int'($past(pu_step)) - int'(pu_step) <= 1) &&
                     (int'(pd_step) - int'($past(pd_step)) <= 1) &&
                     (int'($past(pd_step)) - int'(pd_step) <= 1)));

    a_r9_flag_source: assert property (@(posedge clk) disable iff (rst)
        rsvd_op |-> ($past(mrs_wr) && ($past(mrs_op) == 3'b011 ||
                     $past(mrs_op) == 3'b101 || $past(mrs_op) == 3'b110)));

    a_r9_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (mrs_wr && op_unused) |=> ($stable(drv_force) && $stable(drv_lvl_dq) &&
                                   $stable(drv_lvl_dqsn)));
endmodule

bind drv_imp_cal drv_imp_cal_chk #(.STEP_W(STEP_W), .DEF_STEP(DEF_STEP)) u_chk (.*);

// File: tb/drv_imp_cal_bench.sv
module drv_imp_cal_bench;
    localparam int STEP_W = 3;
    localparam int DEF    = 4;
    localparam int MAXV   = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mrs_wr = 1'b0;
    logic [2:0] mrs_op = 3'b000;
    logic beat_vld = 1'b0;
    logic beat_dt = 1'b0;
    logic [STEP_W-1:0] pu_step, pd_step;
    logic drv_force, drv_lvl_dq, drv_lvl_dqsn, rsvd_op;

    always #4 clk = ~clk;

    drv_imp_cal #(.STEP_W(STEP_W), .DEF_STEP(DEF)) u_drv_imp_cal (
        .clk(clk), .rst(rst), .mrs_wr(mrs_wr), .mrs_op(mrs_op),
        .beat_vld(beat_vld), .beat_dt(beat_dt),
        .pu_step(pu_step), .pd_step(pd_step), .drv_force(drv_force),
        .drv_lvl_dq(drv_lvl_dq), .drv_lvl_dqsn(drv_lvl_dqsn), .rsvd_op(rsvd_op)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model state
    int m_mode = 0;
    int m_pu = DEF, m_pd = DEF;
    int m_beats = 0;
    logic [3:0] m_sh = 4'b0, m_code = 4'b0;
    bit m_pend = 0, m_rsvd = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit known(int op);
        return op == 0 || op == 1 || op == 2 || op == 4 || op == 7;
    endfunction

    function automatic int sat(int v);
        return (v < 0) ? 0 : ((v > MAXV) ? MAXV : v);
    endfunction

    // table of pull-up / pull-down moves per code (DT0..DT3 written msb first)
    function automatic void code_moves(logic [3:0] c, output int dpu, output int dpd);
        dpu = 0; dpd = 0;
        case (c)
            4'b0001: dpu = 1;
            4'b0010: dpu = -1;
            4'b0100: dpd = 1;
            4'b1000: dpd = -1;
            4'b0101: begin dpu = 1;  dpd = 1;  end
            4'b0110: begin dpu = -1; dpd = 1;  end
            4'b1001: begin dpu = 1;  dpd = -1; end
            4'b1010: begin dpu = -1; dpd = -1; end
            default: ;
        endcase
    endfunction

    task automatic model_step(bit wr, int op, bit vld, bit dt);
        int dpu, dpd;
        int n_pu = m_pu, n_pd = m_pd, n_beats = m_beats;
        logic [3:0] n_sh = m_sh, n_code = m_code;
        bit n_pend = 0;
        if (wr && op == 7) begin
            n_pu = DEF; n_pd = DEF;
        end else if (m_pend) begin
            code_moves(m_code, dpu, dpd);
            n_pu = sat(m_pu + dpu); n_pd = sat(m_pd + dpd);
        end
        if (wr && op == 4) n_beats = 0;
        else if (m_mode == 4 && vld && !wr) begin
            n_sh = {m_sh[2:0], dt};
            n_beats = (m_beats + 1) % 4;
            if (m_beats == 3) begin n_pend = 1; n_code = n_sh; end
        end
        m_rsvd = wr && !known(op);
        if (wr && known(op)) m_mode = op;
        m_pu = n_pu; m_pd = n_pd; m_beats = n_beats;
        m_sh = n_sh; m_code = n_code; m_pend = n_pend;
    endtask

    task automatic compare_all();
        chk({tag, " pu_step"}, int'(pu_step), m_pu);
        chk({tag, " pd_step"}, int'(pd_step), m_pd);
        chk({tag, " drv_force"}, int'(drv_force), int'(m_mode == 1 || m_mode == 2));
        chk({tag, " drv_lvl_dq"}, int'(drv_lvl_dq), int'(m_mode == 1));
        chk({tag, " drv_lvl_dqsn"}, int'(drv_lvl_dqsn), int'(m_mode == 2));
        chk({tag, " rsvd_op"}, int'(rsvd_op), int'(m_rsvd));
    endtask

    // called at a negedge; drives, lets one edge pass, checks at next negedge
    task automatic cyc(bit wr, int op, bit vld, bit dt);
        mrs_wr = wr; mrs_op = op[2:0]; beat_vld = vld; beat_dt = dt;
        @(posedge clk);
        #1 model_step(wr, op, vld, dt);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_op(int op);
        cyc(1, op, 0, 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic burst(logic [3:0] c);
        for (int i = 3; i >= 0; i--) cyc(0, 0, 1, c[i]);
        idle(2);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R1 reset";
        compare_all();

        tag = "R2 drive high";
        wr_op(1); idle(1);
        tag = "R2 drive low";
        wr_op(2); idle(1);

        tag = "R9 unused op";
        wr_op(1);
        wr_op(3); wr_op(5); wr_op(6); idle(2);

        tag = "R6 code table";
        wr_op(4);
        begin
            logic [3:0] codes [9] = '{4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                      4'b0101, 4'b0110, 4'b1001, 4'b1010};
            foreach (codes[i]) burst(codes[i]);
        end

        tag = "R7 reserved code";
        burst(4'b0011); burst(4'b1100); burst(4'b1111); burst(4'b0111); burst(4'b1101);

        tag = "R8 saturate high";
        for (int i = 0; i < 9; i++) burst(4'b0101);
        chk("R8 pu at top", int'(pu_step), MAXV);
        chk("R8 pd at top", int'(pd_step), MAXV);
        tag = "R8 saturate low";
        for (int i = 0; i < 9; i++) burst(4'b1010);
        chk("R8 pu at bottom", int'(pu_step), 0);
        chk("R8 pd at bottom", int'(pd_step), 0);

        tag = "R4 default load";
        wr_op(7); idle(1);
        chk("R4 pu default", int'(pu_step), DEF);

        tag = "R5 restart burst";
        wr_op(4);
        cyc(0, 0, 1, 1); cyc(0, 0, 1, 0);
        wr_op(4);
        burst(4'b0001);
        tag = "R5 beat blocked by write";
        cyc(0, 0, 1, 0); cyc(0, 0, 1, 1);
        cyc(1, 2, 1, 1);
        wr_op(4);
        burst(4'b0100);
        tag = "R5 back to back";
        for (int i = 3; i >= 0; i--) cyc(0, 0, 1, i[0]);
        for (int i = 3; i >= 0; i--) cyc(0, 0, 1, 4'b1001 >> i);
        idle(2);

        tag = "R3 exit holds steps";
        burst(4'b0101);
        wr_op(0); idle(2);
        chk("R3 pu held", int'(pu_step), m_pu);

        tag = "R10 beats outside adjust";
        cyc(0, 0, 1, 0); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0); idle(2);
        wr_op(1);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1);
        idle(2);
        wr_op(4);
        cyc(0, 0, 1, 0);
        idle(3);

        tag = "R5 random";
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 6) wr_op($urandom_range(0, 7));
            else if (r < 10) wr_op(4);
            else if (r < 75) cyc(0, 0, 1, $urandom_range(0, 1));
            else cyc(0, 0, 0, $urandom_range(0, 1));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule